// File: doc/BRIEF.md
# Branch-Policy Fetch Controller

This block is the fetch front end of an in-order pipeline. The pipeline has three tracked stages: fetch (stage 1), decode (stage 2) and resolve (stage 3). A conditional branch learns its direction and target only at the end of the resolve stage. A fetch that depends on that outcome can therefore happen no earlier than three cycles after the branch itself was fetched.

The controller produces the fetch address and a fetch-valid strobe every cycle. It takes a decode-time flag that marks the instruction in decode as a branch, and the taken bit and target for the instruction in the resolve stage. It tracks which stage slots hold live instructions. It raises kill bits for the decode and fetch slots when a prediction was wrong. It also counts every wasted slot, which lets cycles-per-instruction figures be read off directly.

A static policy input picks how branches are handled. Fetch can idle for two slots after each branch. Fetch can assume fall-through and squash the two younger slots on a taken branch. Or the two slots after a branch can be architectural delay slots that always execute. All ports are plain control and status pins, with no flow control at the edge. The policy input is meant to change only while reset is asserted.

Top module: `brfetch_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fe_addr is 0, fe_valid is 1, kill_fe and kill_de are 0, and waste_cnt is 0.
- R2: When fe_valid is 1 and no redirect occurs, the next fe_addr is the current fe_addr plus 4. When fe_valid is 0 and no redirect occurs, fe_addr holds its value.
- R3: With pol_sel = 0 (idle policy), a branch fetched in cycle t drives fe_valid low in cycles t+1 and t+2. In cycle t+3 fe_addr is the target if the branch is taken and the branch address plus 4 if it is not. kill_fe and kill_de stay 0 in this policy.
- R4: With pol_sel = 1 (fall-through policy), a taken branch fetched in cycle t raises kill_de and kill_fe together in cycle t+2, and fe_addr in cycle t+3 is the target.
- R5: With pol_sel = 1, a not-taken branch costs nothing. fe_valid stays 1, no kill bit rises, and fetch stays sequential.
- R6: With pol_sel = 2 or 3 (delay-slot policy), the two instructions after a branch are fetched and never killed. In cycle t+3 fe_addr is the target if the branch is taken and the branch address plus 12 if it is not.
- R7: With the delay-slot policy, a branch flag raised for either delay slot of a branch is ignored. It causes no redirect and no extra slot.
- R8: With pol_sel = 1, a branch flag raised for a slot that is killed by an older taken branch is ignored.
- R9: waste_cnt grows by one for each cycle with fe_valid low and by one for each raised kill bit, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 2 | Branch policy: 0 idle, 1 fall-through with squash, 2 or 3 delay slots |
| dec_is_br | input | 1 | The instruction now in decode is a branch |
| rsv_taken | input | 1 | Taken outcome of the instruction now in resolve |
| rsv_target | input | AW | Target address of the instruction now in resolve |
| fe_addr | output | AW | Address fetched this cycle |
| fe_valid | output | 1 | This cycle's fetch slot holds a real instruction |
| kill_fe | output | 1 | Squash the instruction fetched this cycle |
| kill_de | output | 1 | Squash the instruction now in decode |
| waste_cnt | output | CW | Count of idle plus squashed slots |

## Verification
fe_valid, kill_fe and kill_de are combinational in the cycle where the decode flag or the resolve outcome is presented. fe_addr reflects a redirect or a sequential step one clock edge later. waste_cnt includes a slot from the edge that closes that slot. The bench presents the decode flag and outcome for each cycle at the falling edge, derived from its own record of which addresses sit in decode and resolve. It samples one time unit later and compares each cycle against a trace computed from the branch fetch cycle (t = 4), so the idle slots land at t+1 and t+2, the kills at t+2 and the redirect at t+3.

// File: rtl/brfetch_pkg.sv
package brfetch_pkg;
  typedef enum logic [1:0] {
    POL_IDLE  = 2'd0,
    POL_SQASH = 2'd1,
    POL_DSLOT = 2'd2
  } pol_e;

  localparam int unsigned DSLOTS   = 2;
  localparam int unsigned DSLOT_W  = $clog2(DSLOTS + 1);
  localparam int unsigned STEP     = 4;

  function automatic pol_e decode_pol(input logic [1:0] sel);
    case (sel)
      2'd0:    return POL_IDLE;
      2'd1:    return POL_SQASH;
      default: return POL_DSLOT;
    endcase
  endfunction
endpackage

// File: rtl/brfetch_slots.sv
module brfetch_slots
  import brfetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pol_e pol,
  input  logic dec_is_br,
  input  logic rsv_taken,
  output logic fe_valid,
  output logic kill_fe,
  output logic kill_de,
  output logic redir
);
  logic               live_de;
  logic               br_rsv;
  logic [DSLOT_W-1:0] shadow_left;
  logic               br_de;
  logic               in_shadow;

  assign in_shadow = (pol == POL_DSLOT) && (shadow_left != '0);
  assign br_de     = dec_is_br && live_de && !in_shadow;
  assign redir     = br_rsv && rsv_taken;
  assign fe_valid  = !((pol == POL_IDLE) && (br_de || br_rsv));
  assign kill_de   = redir && (pol == POL_SQASH) && live_de;
  assign kill_fe   = redir && (pol == POL_SQASH) && fe_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_de     <= 1'b0;
      br_rsv      <= 1'b0;
      shadow_left <= '0;
    end else begin
      live_de <= fe_valid && !kill_fe;
      br_rsv  <= br_de && !kill_de;
      if ((pol == POL_DSLOT) && br_de)
        shadow_left <= DSLOT_W'(DSLOTS);
      else if (live_de && (shadow_left != '0))
        shadow_left <= shadow_left - 1'b1;
    end
  end
endmodule

// File: rtl/brfetch_pcgen.sv
module brfetch_pcgen
  import brfetch_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fe_valid,
  input  logic          redir,
  input  logic [AW-1:0] rsv_target,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      pc <= '0;
    else if (redir)
      pc <= rsv_target;
    else if (fe_valid)
      pc <= pc + AW'(STEP);
  end
endmodule

// File: rtl/brfetch_waste.sv
module brfetch_waste #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fe_valid,
  input  logic          kill_fe,
  input  logic          kill_de,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] inc;

  assign inc = CW'(!fe_valid) + CW'(kill_fe) + CW'(kill_de);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + inc;
  end
endmodule

// File: rtl/brfetch_ctl.sv
module brfetch_ctl
  import brfetch_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pol_sel,
  input  logic          dec_is_br,
  input  logic          rsv_taken,
  input  logic [AW-1:0] rsv_target,
  output logic [AW-1:0] fe_addr,
  output logic          fe_valid,
  output logic          kill_fe,
  output logic          kill_de,
  output logic [CW-1:0] waste_cnt
);
  pol_e pol;
  logic redir;

  assign pol = decode_pol(pol_sel);

  brfetch_slots u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol      (pol),
    .dec_is_br(dec_is_br),
    .rsv_taken(rsv_taken),
    .fe_valid (fe_valid),
    .kill_fe  (kill_fe),
    .kill_de  (kill_de),
    .redir    (redir)
  );

  brfetch_pcgen #(.AW(AW)) u_pcgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .fe_valid  (fe_valid),
    .redir     (redir),
    .rsv_target(rsv_target),
    .pc        (fe_addr)
  );

  brfetch_waste #(.CW(CW)) u_waste (
    .clk     (clk),
    .rst_n   (rst_n),
    .fe_valid(fe_valid),
    .kill_fe (kill_fe),
    .kill_de (kill_de),
    .cnt     (waste_cnt)
  );
endmodule

// File: rtl/brfetch_ctl_chk.sv
module brfetch_ctl_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pol_sel,
  input logic [AW-1:0] rsv_target,
  input logic [AW-1:0] fe_addr,
  input logic          fe_valid,
  input logic          kill_fe,
  input logic          kill_de,
  input logic [CW-1:0] waste_cnt,
  input logic          redir
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (fe_addr == '0 && waste_cnt == '0));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && !redir) |=> fe_addr == $past(fe_addr) + AW'(4));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_valid && !redir) |=> $stable(fe_addr));

  a_r3_idle_nokill: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 2'd0) |-> !(kill_fe || kill_de));

  a_r4_kill_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 2'd1) |-> (kill_fe == kill_de));

  a_r4_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> fe_addr == $past(rsv_target));

  a_r6_dslot_nokill: assert property (@(posedge clk) disable iff (!rst_n)
    pol_sel[1] |-> !(kill_fe || kill_de));

  a_r9_waste_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && !kill_fe && !kill_de) |=> $stable(waste_cnt));
endmodule

bind brfetch_ctl brfetch_ctl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pol_sel   (pol_sel),
  .rsv_target(rsv_target),
  .fe_addr   (fe_addr),
  .fe_valid  (fe_valid),
  .kill_fe   (kill_fe),
  .kill_de   (kill_de),
  .waste_cnt (waste_cnt),
  .redir     (redir)
);

// File: tb/brfetch_ctl_tb_top.sv
module brfetch_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NCYC = 16;
  localparam logic [AW-1:0] BR_ADDR = 32'h10;
  localparam logic [AW-1:0] BR_TGT  = 32'h100;
  localparam logic [AW-1:0] SH_TGT  = 32'h200;
  localparam logic [AW-1:0] NOWHERE = 32'hFFFF_FFF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pol_sel = 2'd0;
  logic          dec_is_br = 1'b0;
  logic          rsv_taken = 1'b0;
  logic [AW-1:0] rsv_target = '0;
  logic [AW-1:0] fe_addr;
  logic          fe_valid;
  logic          kill_fe;
  logic          kill_de;
  logic [CW-1:0] waste_cnt;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  bit  sh_on;
  bit  case_tk;
  logic [AW-1:0] sh_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  brfetch_ctl #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .dec_is_br(dec_is_br),
    .rsv_taken(rsv_taken), .rsv_target(rsv_target), .fe_addr(fe_addr),
    .fe_valid(fe_valid), .kill_fe(kill_fe), .kill_de(kill_de),
    .waste_cnt(waste_cnt)
  );

  function automatic bit is_br(input logic [AW-1:0] a);
    return (a == BR_ADDR) || (sh_on && a == sh_addr);
  endfunction

  function automatic bit br_tk(input logic [AW-1:0] a);
    return (a == BR_ADDR) ? case_tk : 1'b1;
  endfunction

  function automatic logic [AW-1:0] br_tgt(input logic [AW-1:0] a);
    return (a == BR_ADDR) ? BR_TGT : SH_TGT;
  endfunction

  task automatic chk(input string req, input string what, input int cyc,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s pol=%0d tk=%0d sh=%0d cycle=%0d act=%0h exp=%0h",
               req, what, pol_sel, case_tk, sh_on, cyc, act, exp);
    end
  endtask

  task automatic run_case(input logic [1:0] m, input bit tk, input int sh);
    logic [AW-1:0] s2;
    logic [AW-1:0] s3;
    bit idle_pol;
    bit sq_pol;
    pol_sel  = m;
    case_tk  = tk;
    sh_on    = (sh != 0);
    sh_addr  = BR_ADDR + AW'(4 * sh);
    idle_pol = (m == 2'd0);
    sq_pol   = (m == 2'd1);
    rst_n = 1'b0; dec_is_br = 1'b0; rsv_taken = 1'b0; rsv_target = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    s2 = NOWHERE;
    s3 = NOWHERE;
    for (int c = 0; c < NCYC; c++) begin
      logic [AW-1:0] e_addr;
      logic          e_vld;
      logic          e_kill;
      string         req;
      if (c > 0) @(negedge clk);
      dec_is_br  = is_br(s2);
      rsv_taken  = br_tk(s3);
      rsv_target = br_tgt(s3);
      #1;
      if (c <= 4 || (!idle_pol && c <= 6)) begin
        e_addr = AW'(4 * c); e_vld = 1'b1;
      end else if (c <= 6) begin
        e_addr = BR_ADDR + AW'(4); e_vld = 1'b0;
      end else begin
        e_vld  = 1'b1;
        e_addr = tk ? BR_TGT + AW'(4 * (c - 7))
                    : (idle_pol ? AW'(4 * (c - 2)) : AW'(4 * c));
      end
      e_kill = sq_pol && tk && (c == 6);
      if (c < 4)         req = "R2";
      else if (idle_pol) req = "R3";
      else if (sq_pol)   req = sh_on ? "R8" : (tk ? "R4" : "R5");
      else               req = sh_on ? "R7" : "R6";
      if (c == 0) begin
        chk("R1", "waste_cnt", c, AW'(waste_cnt), '0);
        chk("R1", "fe_addr", c, fe_addr, '0);
        chk("R1", "fe_valid", c, AW'(fe_valid), AW'(1));
        chk("R1", "kill_fe", c, AW'(kill_fe), '0);
      end
      chk(req, "fe_addr", c, fe_addr, e_addr);
      chk(req, "fe_valid", c, AW'(fe_valid), AW'(e_vld));
      chk(req, "kill_fe", c, AW'(kill_fe), AW'(e_kill));
      chk(req, "kill_de", c, AW'(kill_de), AW'(e_kill));
      s3 = s2;
      s2 = fe_addr;
    end
    chk("R9", "waste_cnt", NCYC - 1, AW'(waste_cnt),
        (idle_pol || (sq_pol && tk)) ? AW'(2) : AW'(0));
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int tk = 0; tk < 2; tk++)
        for (int sh = 0; sh < 3; sh++) begin
          if (sh != 0 && (m == 0 || (m == 1 && tk == 0))) continue;
          run_case(2'(m), tk[0], sh);
        end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule